// File: doc/BRIEF.md
# Shared Two-Source Interrupt Vector Register

This block holds one programmable interrupt vector number that two serial units share: a queued synchronous serial unit (SPI) and an asynchronous serial unit (SCI). Software programs the upper seven bits of the vector through a simple register port. When the interrupt controller acknowledges, the block returns the full 8-bit vector. It fills in the least significant bit itself from the source being served, so the two sources always land on two neighbouring vector numbers.

Each source raises a request line. A rising edge on that line makes the request pending. The pending request clears when it is served or when the source drops the line. If both requests are pending at an acknowledge, the SPI request is served first and the SCI request stays pending for the next acknowledge. The vector is presented on a registered output together with a valid flag, which is high in the single cycle after the acknowledge strobe.

Top module: `irq_vec_share`

## Requirements
- R1: After reset, rdData reads 0x0F (the vector for an uninitialized interrupt), vecValid is 0 and irqOut is 0.
- R2: A write with wrEn high stores wrData[7:1], and from the next cycle rdData[7:1] returns it. wrData[0] has no effect on any stored state, on rdData or on any vector later returned.
- R3: rdData[0] always reads 1.
- R4: An acknowledge (ackStb high at a clock edge) that serves the SPI request gives, after that edge, vecValid=1 and vecOut = {stored bits 7:1 as they were before that edge, 1}.
- R5: An acknowledge that serves the SCI request gives vecOut = {stored bits 7:1 as they were before that edge, 0} with vecValid=1.
- R6: When both requests are pending at an acknowledge, the SPI request is served, the SCI request stays pending, and the next acknowledge serves the SCI request.
- R7: vecValid is high only in the cycle after an edge with ackStb high. An acknowledge while nothing is pending leaves vecValid at 0.
- R8: A request becomes pending on a rising edge of its line. It is dropped when its line goes low, and it is cleared when served. A line that stays high after its request is served does not make the request pending again until the line falls and rises.
- R9: irqOut is 1 exactly when at least one request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data. Bit 0 is ignored |
| rdData | output | 8 | Register read value. Bit 0 reads 1 |
| reqSci | input | 1 | Request line of the asynchronous serial unit |
| reqSpi | input | 1 | Request line of the synchronous serial unit |
| ackStb | input | 1 | Interrupt acknowledge strobe |
| irqOut | output | 1 | High while any request is pending |
| vecOut | output | 8 | Acknowledged vector number |
| vecValid | output | 1 | vecOut is valid in this cycle |

## Verification
The assertions check on every cycle the properties that depend only on local time. These are: the valid flag follows an acknowledge, the vector LSB tracks the source that is pending, the upper vector bits match the value read back one cycle before, SPI wins a tie, and a dropped line clears its pending request. Only the bench scenarios can show the longer behaviours. It sweeps all 256 write values to show that bit 0 never reaches the stored value or the vectors. It also shows that the SCI request waits through a tie and is served by the second acknowledge, and that a request line held high does not become pending again after it is served.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture write data into the vector register
    logic emit;   // present the vector on the output this edge
    logic lsb;    // LSB to attach: 1 for SPI, 0 for SCI
  } vecStrobe_t;

  // Source indices; the index is the LSB of the vector, and the higher index wins a tie
  localparam int SRC_SCI = 0;
  localparam int SRC_SPI = 1;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
  import irq_vec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               ackStb,
  output logic [NUM_SRC-1:0] pending,
  output vecStrobe_t         strobe
);
  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] grant;

  // Fixed priority: the highest index wins
  always_comb begin
    grant = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i] && grant == '0) grant[i] = ackStb;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gSrc
      logic riseSeen;
      assign riseSeen = reqIn[g] & ~reqPrev[g];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          reqPrev[g] <= 1'b0;
          pending[g] <= 1'b0;
        end else begin
          reqPrev[g] <= reqIn[g];
          pending[g] <= (pending[g] | riseSeen) & reqIn[g] & ~grant[g];
        end
      end
    end
  endgenerate

  always_comb begin
    strobe.load = wrEn;
    strobe.emit = |grant;
    strobe.lsb  = grant[SRC_SPI];
  end
endmodule

// File: rtl/irq_vec_dp.sv
module irq_vec_dp
  import irq_vec_pkg::*;
#(
  parameter int          VEC_W   = 8,
  parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  vecStrobe_t       strobe,
  input  logic [VEC_W-1:1] wrHi,
  output logic [VEC_W-1:0] rdData,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);
  logic [VEC_W-1:1] vecHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecHi    <= RST_VEC[VEC_W-1:1];
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      if (strobe.load) vecHi <= wrHi;
      if (strobe.emit) vecOut <= {vecHi, strobe.lsb};
      vecValid <= strobe.emit;
    end
  end

  assign rdData = {vecHi, 1'b1};
endmodule

// File: rtl/irq_vec_share.sv
module irq_vec_share
  import irq_vec_pkg::*;
#(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [VEC_W-1:0] wrData,
  output logic [VEC_W-1:0] rdData,
  input  logic             reqSci,
  input  logic             reqSpi,
  input  logic             ackStb,
  output logic             irqOut,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);
  vecStrobe_t         strobe;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] reqIn;
  logic               pendSci;
  logic               pendSpi;
  logic               unusedWrLsb;

  assign unusedWrLsb    = wrData[0];
  assign reqIn[SRC_SCI] = reqSci;
  assign reqIn[SRC_SPI] = reqSpi;
  assign pendSci        = pending[SRC_SCI];
  assign pendSpi        = pending[SRC_SPI];
  assign irqOut         = |pending;

  irq_vec_ctl i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .reqIn(reqIn),
    .ackStb(ackStb), .pending(pending), .strobe(strobe)
  );

  irq_vec_dp #(.VEC_W(VEC_W), .RST_VEC(RST_VEC)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrHi(wrData[VEC_W-1:1]),
    .rdData(rdData), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(parameter int VEC_W = 8) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [VEC_W-1:0] wrData,
  input logic [VEC_W-1:0] rdData,
  input logic             reqSci,
  input logic             reqSpi,
  input logic             ackStb,
  input logic             pendSci,
  input logic             pendSpi,
  input logic [VEC_W-1:0] vecOut,
  input logic             vecValid
);
  AST_WR_HI: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[VEC_W-1:1] == $past(wrData[VEC_W-1:1])); // R2
  AST_VEC_HI: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> !vecValid || vecOut[VEC_W-1:1] == $past(rdData[VEC_W-1:1])); // R4
  AST_SCI_LSB: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && !pendSpi && pendSci |=> vecValid && !vecOut[0]); // R5
  AST_SPI_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && pendSpi && pendSci && reqSci |=> vecValid && vecOut[0] && pendSci); // R6
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !ackStb |=> !vecValid); // R7
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && !pendSpi && !pendSci |=> !vecValid); // R7
  AST_DROP_SPI: assert property (@(posedge clk) disable iff (!rstN)
    !reqSpi |=> !pendSpi); // R8
  AST_DROP_SCI: assert property (@(posedge clk) disable iff (!rstN)
    !reqSci |=> !pendSci); // R8
endmodule

bind irq_vec_share irq_vec_chk #(.VEC_W(VEC_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .reqSci(reqSci), .reqSpi(reqSpi), .ackStb(ackStb), .pendSci(pendSci),
  .pendSpi(pendSpi), .vecOut(vecOut), .vecValid(vecValid)
);

// File: tb/test_irq_vec_share.sv
module test_irq_vec_share;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       reqSci = 1'b0;
  logic       reqSpi = 1'b0;
  logic       ackStb = 1'b0;
  logic       irqOut;
  logic [7:0] vecOut;
  logic       vecValid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vec_share i_irq_vec_share (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .reqSci(reqSci), .reqSpi(reqSpi), .ackStb(ackStb), .irqOut(irqOut),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
    finishRun();
  end

  initial begin
    logic [7:0] prev;
    @(negedge clk);
    tick();
    rstN = 1'b1;
    chk("R1 rdData", rdData, 8'h0F);
    chk("R1 vecValid", {7'b0, vecValid}, 8'h00);
    chk("R1 irqOut", {7'b0, irqOut}, 8'h00);
    // Acknowledge with nothing pending
    ackStb = 1'b1; tick(); ackStb = 1'b0;
    chk("R7 idle ack", {7'b0, vecValid}, 8'h00);

    // Sweep every write value
    for (int v = 0; v < 256; v++) begin
      wrEn = 1'b1; wrData = 8'(v); tick(); wrEn = 1'b0;
      chk("R2 R3 readback", rdData, 8'(v) | 8'h01);
      reqSci = 1'b1; tick();
      chk("R9 irq sci", {7'b0, irqOut}, 8'h01);
      ackStb = 1'b1; tick(); ackStb = 1'b0;
      chk("R5 sci valid", {7'b0, vecValid}, 8'h01);
      chk("R5 sci vector", vecOut, 8'(v) & 8'hFE);
      chk("R8 no repend", {7'b0, irqOut}, 8'h00);
      tick();
      chk("R7 one cycle", {7'b0, vecValid}, 8'h00);
      reqSci = 1'b0; reqSpi = 1'b1; tick();
      ackStb = 1'b1; tick(); ackStb = 1'b0;
      chk("R4 spi vector", vecOut, 8'(v) | 8'h01);
      chk("R4 spi valid", {7'b0, vecValid}, 8'h01);
      reqSpi = 1'b0; tick();
    end

    // Tie: SPI first, SCI waits
    wrEn = 1'b1; wrData = 8'h64; tick(); wrEn = 1'b0;
    reqSci = 1'b1; reqSpi = 1'b1; tick();
    ackStb = 1'b1; tick();
    chk("R6 spi first", vecOut, 8'h65);
    chk("R6 sci waits", {7'b0, irqOut}, 8'h01);
    tick();
    chk("R6 sci second", vecOut, 8'h64);
    chk("R6 valid second", {7'b0, vecValid}, 8'h01);
    chk("R9 none left", {7'b0, irqOut}, 8'h00);
    tick(); ackStb = 1'b0;
    chk("R7 third ack empty", {7'b0, vecValid}, 8'h00);
    reqSci = 1'b0; reqSpi = 1'b0; tick();

    // Deassert before acknowledge drops the request
    reqSci = 1'b1; tick(); reqSci = 1'b0; tick();
    chk("R8 dropped", {7'b0, irqOut}, 8'h00);
    ackStb = 1'b1; tick(); ackStb = 1'b0;
    chk("R8 no vector", {7'b0, vecValid}, 8'h00);

    // Write in the same cycle as the acknowledge: vector uses the old value
    prev = rdData;
    reqSpi = 1'b1; tick();
    wrEn = 1'b1; wrData = 8'hC2; ackStb = 1'b1; tick();
    wrEn = 1'b0; ackStb = 1'b0;
    chk("R4 old value", vecOut, prev | 8'h01);
    chk("R2 new value", rdData, 8'hC3);
    reqSpi = 1'b0; tick();
    finishRun();
  end
endmodule